// File: doc/BRIEF.md
# Asynchronous SRAM Bus Cycle Controller

This block sits between a clocked host and a 32K x 8 asynchronous static RAM. It turns a single-beat read or write request into the strobe sequence the memory needs. The host holds `host_req` high along with a direction flag, an address and write data. The controller drives active-low chip enable, output enable and write enable, a registered address and a data bus with a separate drive enable. When the transfer is finished it returns one `host_done` pulse, with the read byte on reads. The host drops its request in the cycle it sees `host_done`.

Every memory timing minimum (access time, write pulse, data setup, address hold, output turn-off, cycle time) is stored per speed grade in ns. Each is rounded up to whole cycles of the `CLK_NS` clock period. Output enable stays high for the whole of every write, so the controller and the memory never drive the data bus at the same time. A supervisor's `wr_protect` input blocks new cycles. A request seen while it is high completes at once with `host_err`, and no strobe moves.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While `rst_n` is low and after reset, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1 and `mem_dq_oe`, `host_done` and `host_err` are 0.
- R2: A read (`host_we`=0) accepted at edge E0 holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for exactly RDC cycles after E0. The memory byte is captured at edge E0+RDC, and `host_done` with `host_rdata` is valid in the cycle after that edge.
- R3: A write (`host_we`=1) accepted at E0 holds `mem_ce_n`=0 and `mem_we_n`=0 for exactly WPC cycles. `mem_oe_n` stays 1 throughout, and `host_done` follows edge E0+WPC.
- R4: `mem_dq_oe` is 1 from the first write-pulse cycle through the end of write recovery, WPC+WRC cycles in all. It is never 1 while `mem_oe_n` is 0, and it falls at least one cycle before output enable can next fall.
- R5: `mem_addr` and the write data are latched at acceptance and stay stable while `mem_ce_n` is 0, whatever the host inputs do afterwards.
- R6: After chip enable rises, it stays high for RRC+1 cycles after a read and WRC+1 cycles after a write before the next cycle starts.
- R7: Cycle counts use ceil(ns/CLK_NS), at least 1. RDC = max(address access, OE access, cycle time). WPC = max(write pulse, data setup). RRC = output turn-off. WRC = max(ceil(max(CE address hold, WE address hold)), ceil(cycle)-WPC).
  - Fast grade (0): access 85, OE access 45, cycle 85, pulse 65, setup 35, turn-off 35, CE hold 15, WE hold 5.
  - Slow grade (1): access 100, OE access 50, cycle 100, pulse 75, setup 40, turn-off 40, CE hold 15, WE hold 5.
- R8: A request seen in idle while `wr_protect`=1 produces no strobe and no write. `host_done` and `host_err` are both 1 in the single following cycle.
- R9: `wr_protect` rising during a cycle already started does not cut it short; the write still lands with full pulse width.
- R10: `host_req` is looked at only in idle. A request held high produces back-to-back cycles, each separated as in R6.
- R11: `host_done` is a one-cycle pulse per request, and `host_err` is 0 for performed cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Request, held until `host_done` |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte address |
| host_wdata | input | DATA_W | Write byte |
| host_rdata | output | DATA_W | Read byte, valid with `host_done` |
| host_done | output | 1 | One-cycle completion pulse |
| host_err | output | 1 | Request refused by write protect |
| wr_protect | input | 1 | Supervisor write-protect, blocks new cycles |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | DATA_W | Data from memory |

## Verification
With the request set before edge E0, the strobes are low in the RDC cycles after E0 on reads and in the WPC cycles on writes. `host_done` follows one cycle later on performed cycles and in the very first cycle on refused ones. The bench recomputes RDC, RRC, WPC and WRC by repeated addition of the clock period. It samples every output on the falling edge, numbering the cycles from E0, and compares each strobe's low count, the done cycle and the drive-enable count against those numbers. For back-to-back requests it counts the high cycles of chip enable between two accesses.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD     = 3'd1,
    ST_RD_REC = 3'd2,
    ST_WR     = 3'd3,
    ST_WR_REC = 3'd4,
    ST_PROT   = 3'd5
  } seq_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // whole cycles covering ns, never below one
  function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  // per-grade minimums in ns, grade 0 = fast, 1 = slow
  function automatic int unsigned t_access(input int grade);   return (grade != 0) ? 100 : 85; endfunction
  function automatic int unsigned t_oe_access(input int grade); return (grade != 0) ? 50 : 45; endfunction
  function automatic int unsigned t_cycle(input int grade);    return (grade != 0) ? 100 : 85; endfunction
  function automatic int unsigned t_wpulse(input int grade);   return (grade != 0) ? 75 : 65; endfunction
  function automatic int unsigned t_dsetup(input int grade);   return (grade != 0) ? 40 : 35; endfunction
  function automatic int unsigned t_turnoff(input int grade);  return (grade != 0) ? 40 : 35; endfunction
  function automatic int unsigned t_ce_ahold(input int grade); return (grade != 0) ? 15 : 15; endfunction
  function automatic int unsigned t_we_ahold(input int grade); return (grade != 0) ? 5 : 5; endfunction

  function automatic int unsigned rd_cycles(input int grade, input int unsigned clk_ns);
    return ns_to_cycles(max2(max2(t_access(grade), t_oe_access(grade)), t_cycle(grade)), clk_ns);
  endfunction

  function automatic int unsigned rd_rec_cycles(input int grade, input int unsigned clk_ns);
    return ns_to_cycles(t_turnoff(grade), clk_ns);
  endfunction

  function automatic int unsigned wr_cycles(input int grade, input int unsigned clk_ns);
    return max2(ns_to_cycles(t_wpulse(grade), clk_ns), ns_to_cycles(t_dsetup(grade), clk_ns));
  endfunction

  function automatic int unsigned wr_rec_cycles(input int grade, input int unsigned clk_ns);
    int unsigned hold_c, wc_c, wp_c, rest;
    hold_c = ns_to_cycles(max2(t_ce_ahold(grade), t_we_ahold(grade)), clk_ns);
    wc_c   = ns_to_cycles(t_cycle(grade), clk_ns);
    wp_c   = wr_cycles(grade, clk_ns);
    rest   = (wc_c > wp_c) ? (wc_c - wp_c) : 0;
    return max2(hold_c, rest);
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);

  // R7: a freshly loaded phase never reports its end in its first cycle unless loaded with zero
  p_load_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> !last);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int             CNT_W     = 4,
  parameter logic [CNT_W-1:0] RD_LD     = '0,
  parameter logic [CNT_W-1:0] RD_REC_LD = '0,
  parameter logic [CNT_W-1:0] WR_LD     = '0,
  parameter logic [CNT_W-1:0] WR_REC_LD = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_req,
  input  logic             host_we,
  input  logic             wr_protect,
  input  logic             phase_last,
  output seq_state_e       state_d,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             prot_hit,
  output logic             rd_capture,
  output logic             wr_finish
);

  seq_state_e state_q;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (host_req) begin
          if (wr_protect) begin
            state_d = ST_PROT;
          end else if (host_we) begin
            state_d  = ST_WR;
            tmr_load = 1'b1;
            tmr_val  = WR_LD;
          end else begin
            state_d  = ST_RD;
            tmr_load = 1'b1;
            tmr_val  = RD_LD;
          end
        end
      end
      ST_RD: begin
        if (phase_last) begin
          state_d  = ST_RD_REC;
          tmr_load = 1'b1;
          tmr_val  = RD_REC_LD;
        end
      end
      ST_RD_REC: if (phase_last) state_d = ST_IDLE;
      ST_WR: begin
        if (phase_last) begin
          state_d  = ST_WR_REC;
          tmr_load = 1'b1;
          tmr_val  = WR_REC_LD;
        end
      end
      ST_WR_REC: if (phase_last) state_d = ST_IDLE;
      ST_PROT:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign accept     = (state_q == ST_IDLE) && host_req;
  assign prot_hit   = accept && wr_protect;
  assign rd_capture = (state_q == ST_RD) && phase_last;
  assign wr_finish  = (state_q == ST_WR) && phase_last;

  // R8: a refused request is followed by exactly one cycle in the refusal state
  p_prot_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prot_hit |=> (state_q == ST_PROT) ##1 (state_q == ST_IDLE));

  // R10: nothing new starts outside idle
  p_no_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> !accept);

endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 8,
  parameter int WP_CYC  = 4,
  parameter int MIN_GAP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state_d,
  input  logic              accept,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);

  localparam int WW = $clog2(WP_CYC + 2);
  localparam int GW = $clog2(MIN_GAP + 2);

  logic ce_d, oe_d, we_d, dqoe_d;

  always_comb begin
    ce_d   = (state_d == ST_RD) || (state_d == ST_WR);
    oe_d   = (state_d == ST_RD);
    we_d   = (state_d == ST_WR);
    dqoe_d = (state_d == ST_WR) || (state_d == ST_WR_REC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      mem_ce_n  <= !ce_d;
      mem_oe_n  <= !oe_d;
      mem_we_n  <= !we_d;
      mem_dq_oe <= dqoe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= host_addr;
      mem_dq_out <= host_wdata;
    end
  end

  // observation counters for the window checks
  logic [WW-1:0] we_lo_cnt;
  logic [GW-1:0] ce_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo_cnt <= '0;
      ce_hi_cnt <= GW'(MIN_GAP);
    end else begin
      if (!mem_we_n) begin
        if (we_lo_cnt != WW'(WP_CYC + 1)) we_lo_cnt <= we_lo_cnt + 1'b1;
      end else begin
        we_lo_cnt <= '0;
      end
      if (mem_ce_n) begin
        if (ce_hi_cnt != GW'(MIN_GAP)) ce_hi_cnt <= ce_hi_cnt + 1'b1;
      end else begin
        ce_hi_cnt <= '0;
      end
    end
  end

  // R3: output enable never low during a write pulse
  p_oe_high_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  // R4: host driver and memory outputs never overlap
  p_no_contention_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R5: address steady while chip enable stays low
  p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr) && $stable(mem_dq_out));

  // R7: the write pulse has its full computed length
  p_we_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo_cnt == WW'(WP_CYC)));

  // R6: chip enable high for at least the shortest recovery plus idle
  p_ce_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> (ce_hi_cnt == GW'(MIN_GAP)));

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int SPEED_GRADE = 0,
  parameter int CLK_NS      = 20,
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_done,
  output logic              host_err,
  input  logic              wr_protect,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int RD_CYC  = int'(rd_cycles(SPEED_GRADE, CLK_NS));
  localparam int RD_REC  = int'(rd_rec_cycles(SPEED_GRADE, CLK_NS));
  localparam int WR_CYC  = int'(wr_cycles(SPEED_GRADE, CLK_NS));
  localparam int WR_REC  = int'(wr_rec_cycles(SPEED_GRADE, CLK_NS));
  localparam int MAX_PH  = int'(max2(max2(RD_CYC, RD_REC), max2(WR_CYC, WR_REC)));
  localparam int CNT_W   = (MAX_PH > 1) ? $clog2(MAX_PH) : 1;
  localparam int MIN_GAP = int'(max2(1, (RD_REC < WR_REC) ? RD_REC : WR_REC)) + 1;

  localparam logic [CNT_W-1:0] RD_LD     = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] RD_REC_LD = CNT_W'(RD_REC - 1);
  localparam logic [CNT_W-1:0] WR_LD     = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] WR_REC_LD = CNT_W'(WR_REC - 1);

  seq_state_e       state_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             phase_last;
  logic             accept;
  logic             prot_hit;
  logic             rd_capture;
  logic             wr_finish;

  sram_phase_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (phase_last)
  );

  sram_seq_fsm #(
    .CNT_W     (CNT_W),
    .RD_LD     (RD_LD),
    .RD_REC_LD (RD_REC_LD),
    .WR_LD     (WR_LD),
    .WR_REC_LD (WR_REC_LD)
  ) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_req   (host_req),
    .host_we    (host_we),
    .wr_protect (wr_protect),
    .phase_last (phase_last),
    .state_d    (state_d),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .accept     (accept),
    .prot_hit   (prot_hit),
    .rd_capture (rd_capture),
    .wr_finish  (wr_finish)
  );

  sram_pin_drive #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .WP_CYC  (WR_CYC),
    .MIN_GAP (MIN_GAP)
  ) pins_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_d    (state_d),
    .accept     (accept),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata <= '0;
      host_done  <= 1'b0;
      host_err   <= 1'b0;
    end else begin
      if (rd_capture) host_rdata <= mem_dq_in;
      host_done <= rd_capture || wr_finish || prot_hit;
      host_err  <= prot_hit;
    end
  end

  // R2: capture happens while the memory is still being read
  p_capture_in_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |-> (!mem_ce_n && !mem_oe_n && mem_we_n));

  // R8: refused request touches no strobe and flags an error
  p_protect_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prot_hit |=> (mem_ce_n && mem_we_n && host_done && host_err));

  // R11: completion is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done);

  // R11: an error is only ever reported with completion
  p_err_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    host_err |-> host_done);

endmodule

// File: tb/sram_cycle_ctrl_tb.sv
module sram_cycle_ctrl_tb_top;

  localparam int AW = 6;
  localparam int DW = 8;
  localparam int T  = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_req = 1'b0;
  logic          host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic          host_done;
  logic          host_err;
  logic          wr_protect = 1'b0;
  logic          mem_ce_n, mem_oe_n, mem_we_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_out;
  logic          mem_dq_oe;
  logic [DW-1:0] mem_dq_in;

  always #10 clk = ~clk;

  sram_cycle_ctrl #(.SPEED_GRADE(0), .CLK_NS(T), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_done(host_done), .host_err(host_err), .wr_protect(wr_protect),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // memory model
  logic [DW-1:0] ram [0:(1<<AW)-1];
  logic [DW-1:0] shadow [0:(1<<AW)-1];
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? ram[mem_addr] : 8'h00;
  always @(negedge clk) if (!mem_ce_n && !mem_we_n && mem_dq_oe) ram[mem_addr] <= mem_dq_out;

  int errors = 0;
  int checks = 0;
  bit ended = 0;

  function automatic int cyc(input int ns);
    int n = 0;
    while (n * T < ns) n++;
    if (n == 0) n = 1;
    return n;
  endfunction
  function automatic int mx(input int a, input int b); return (a > b) ? a : b; endfunction

  // R7 fast grade figures
  int E_RD, E_RRC, E_WP, E_WRC;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int r_ce, r_oe, r_we, r_dqoe, r_done_at, r_done_cnt, r_amove, r_cont;
  logic r_err;
  logic [DW-1:0] r_rd;

  task automatic run_op(input logic we_i, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic wp_i, input logic wp_mid);
    @(negedge clk);
    host_req = 1'b1; host_we = we_i; host_addr = a; host_wdata = d; wr_protect = wp_i;
    r_ce = 0; r_oe = 0; r_we = 0; r_dqoe = 0; r_done_at = 0; r_done_cnt = 0;
    r_amove = 0; r_cont = 0; r_err = 1'b0; r_rd = '0;
    for (int k = 1; k <= 14; k++) begin
      @(negedge clk);
      if (k == 1) begin host_addr = ~a; host_wdata = ~d; end
      if (wp_mid && k == 2) wr_protect = 1'b1;
      if (!mem_ce_n) begin r_ce++; if (mem_addr != a) r_amove++; end
      if (!mem_oe_n) r_oe++;
      if (!mem_we_n) r_we++;
      if (mem_dq_oe) r_dqoe++;
      if (mem_dq_oe && !mem_oe_n) r_cont++;
      if (host_done) begin
        r_done_cnt++;
        if (r_done_at == 0) begin
          r_done_at = k; r_rd = host_rdata; r_err = host_err; host_req = 1'b0;
        end
      end
    end
    wr_protect = 1'b0;
  endtask

  task automatic b2b(input logic we_i, input int exp_gap, input string tag);
    int state, gap;
    state = 0; gap = 0;
    @(negedge clk);
    host_req = 1'b1; host_we = we_i; host_addr = 6'd3; host_wdata = 8'hC3;
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      if (state == 0 && !mem_ce_n) state = 1;
      else if (state == 1 && mem_ce_n) begin state = 2; gap = 1; end
      else if (state == 2) begin
        if (mem_ce_n) gap++; else state = 3;
      end
    end
    host_req = 1'b0;
    repeat (16) @(negedge clk);
    chk(state == 3 && gap == exp_gap, tag, gap, exp_gap);
    if (we_i) shadow[3] = 8'hC3;
  endtask

  initial begin
    E_RD  = cyc(mx(mx(85, 45), 85));
    E_RRC = cyc(35);
    E_WP  = mx(cyc(65), cyc(35));
    E_WRC = mx(cyc(15), mx(cyc(85) - E_WP, 0));
    for (int i = 0; i < (1 << AW); i++) begin ram[i] = 8'h00; shadow[i] = 8'h00; end

    // R1 reset
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !host_done && !host_err,
        "R1 outputs in reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !host_done,
        "R1 outputs after reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);

    // R3 R4 R5 R11 write sweep
    for (int a = 0; a < (1 << AW); a++) begin
      logic [DW-1:0] d;
      d = DW'(a * 29) ^ 8'h5A;
      run_op(1'b1, AW'(a), d, 1'b0, 1'b0);
      shadow[a] = d;
      chk(r_ce == E_WP, "R3 ce low cycles", r_ce, E_WP);
      chk(r_we == E_WP, "R3 we low cycles", r_we, E_WP);
      chk(r_oe == 0, "R3 oe stays high", r_oe, 0);
      chk(r_dqoe == E_WP + E_WRC, "R4 drive window", r_dqoe, E_WP + E_WRC);
      chk(r_cont == 0, "R4 no overlap", r_cont, 0);
      chk(r_amove == 0, "R5 address held", r_amove, 0);
      chk(r_done_at == E_WP + 1, "R3 done cycle", r_done_at, E_WP + 1);
      chk(r_done_cnt == 1 && !r_err, "R11 single done no err", r_done_cnt, 1);
    end

    // R2 R5 read sweep
    for (int a = 0; a < (1 << AW); a++) begin
      run_op(1'b0, AW'(a), 8'h00, 1'b0, 1'b0);
      chk(r_ce == E_RD, "R2 ce low cycles", r_ce, E_RD);
      chk(r_oe == E_RD, "R2 oe low cycles", r_oe, E_RD);
      chk(r_we == 0, "R2 we stays high", r_we, 0);
      chk(r_dqoe == 0, "R4 no drive on read", r_dqoe, 0);
      chk(r_amove == 0, "R5 address held", r_amove, 0);
      chk(r_done_at == E_RD + 1, "R2 done cycle", r_done_at, E_RD + 1);
      chk(r_rd == shadow[a], "R2 read data", r_rd, shadow[a]);
      chk(r_done_cnt == 1 && !r_err, "R11 single done no err", r_done_cnt, 1);
    end

    // R8 protected write and read
    run_op(1'b1, 6'd10, 8'hEE, 1'b1, 1'b0);
    chk(r_ce == 0 && r_we == 0 && r_dqoe == 0, "R8 no strobes on write", r_ce + r_we + r_dqoe, 0);
    chk(r_done_at == 1 && r_err, "R8 immediate error done", r_done_at, 1);
    chk(r_done_cnt == 1, "R8 single done", r_done_cnt, 1);
    run_op(1'b0, 6'd10, 8'h00, 1'b1, 1'b0);
    chk(r_ce == 0 && r_oe == 0, "R8 no strobes on read", r_ce + r_oe, 0);
    chk(r_done_at == 1 && r_err, "R8 read refused", r_done_at, 1);
    run_op(1'b0, 6'd10, 8'h00, 1'b0, 1'b0);
    chk(r_rd == shadow[10], "R8 location unchanged", r_rd, shadow[10]);

    // R9 protect raised mid write
    run_op(1'b1, 6'd20, 8'hA5, 1'b0, 1'b1);
    shadow[20] = 8'hA5;
    chk(r_we == E_WP && !r_err, "R9 pulse completes", r_we, E_WP);
    run_op(1'b0, 6'd20, 8'h00, 1'b0, 1'b0);
    chk(r_rd == 8'hA5, "R9 write landed", r_rd, 8'hA5);

    // R6 R10 back-to-back gaps
    b2b(1'b0, E_RRC + 1, "R6 R10 read gap");
    b2b(1'b1, E_WRC + 1, "R6 R10 write gap");
    run_op(1'b0, 6'd3, 8'h00, 1'b0, 1'b0);
    chk(r_rd == shadow[3], "R10 data after burst", r_rd, shadow[3]);

    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule